// File: doc/BRIEF.md
# Bus Hold Arbiter with Locked-Instruction Guard

This block decides when the processor lets go of the system bus to an external master such as a DMA controller. The external master raises a hold request and must wait for the acknowledge before it drives anything. The acknowledge is given only at a bus-cycle boundary, and only when the bus interface has nothing useful to do: it is stalled by an instruction, it sits in T1 with a full prefetch queue, or it is finishing a T4.

The block also generates the active-low bus lock. A lock-prefixed instruction arms the lock at its start. The lock engages on the instruction's first memory access and drops when the execution unit reports that the instruction is complete. No new grant is given while the lock is engaged. After the hold request is withdrawn, the acknowledge falls, and the processor takes the bus back one clock later.

Top module: `bus_hold_arbiter`

## Requirements
- R1: A synchronous active-low reset leaves `lockN` high, `hlda` low and `cpuBusEn` high.
- R2: After `instrStart` with `lockPrefix` high, the first cycle with `memAccess` high drives `lockN` low on the next edge, whatever the access size. An instruction started with `lockPrefix` low never drives `lockN` low.
- R3: `instrDone` drives `lockN` high on the next edge and disarms a pending lock. It wins over a `memAccess` in the same cycle.
- R4: `hlda` rises only on an edge where `busState` was T1 (code 1) or T4 (code 4). It never rises in idle (0), T2 (2) or T3 (3).
- R5: With `holdReq` high and the lock released, the grant is given on the next edge if either of two conditions holds:
  - `busState` is T4;
  - `busState` is T1 and either `biuStall` or `queueFull` is high.
- R6: No grant is given in any cycle in which `lockN` is low.
- R7: `cpuBusEn` falls on the same edge on which `hlda` rises. Both keep their values for as long as `holdReq` stays high.
- R8: On the edge after `holdReq` is sampled low, `hlda` falls while `cpuBusEn` stays low. `cpuBusEn` rises one edge later, and no grant is given in that gap.
- R9: An instruction started with `lockPrefix` low cancels a lock that was armed but not yet engaged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busState | input | 3 | Bus cycle state: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4 |
| queueFull | input | 1 | Prefetch queue has no free slot |
| biuStall | input | 1 | Bus interface is stalled by an instruction request |
| instrStart | input | 1 | Strobe: a new instruction begins |
| lockPrefix | input | 1 | The starting instruction carries the lock prefix |
| memAccess | input | 1 | Strobe: a memory access of any size is issued |
| instrDone | input | 1 | Strobe: execution of the instruction is complete |
| holdReq | input | 1 | Bus request from the external master |
| lockN | output | 1 | Bus lock, active low |
| hlda | output | 1 | Hold acknowledge to the external master |
| cpuBusEn | output | 1 | High while the processor owns the bus |

## Verification
Every output comes from a flop, so each result is due on the first edge after the inputs that cause it. The exception is the return of `cpuBusEn`, which comes one edge after `hlda` falls. The bench changes inputs on the falling edge and samples on the next falling edge. A check for the resume step therefore waits exactly one further falling edge. The grant sweep runs through every combination of bus state, queue-full and stall, twice: once unlocked and once with the lock engaged. The expected grant is computed from R5 and R6 as a boolean formula in the bench.

// File: rtl/bha_pkg.sv
package bha_pkg;
  localparam int BusStateW = 3;

  typedef enum logic [BusStateW-1:0] {
    BS_IDLE = 3'd0,
    BS_T1   = 3'd1,
    BS_T2   = 3'd2,
    BS_T3   = 3'd3,
    BS_T4   = 3'd4
  } busState_e;

  typedef enum logic [1:0] {
    ARB_OWN     = 2'd0,
    ARB_GRANTED = 2'd1,
    ARB_RESUME  = 2'd2
  } arbState_e;

  typedef struct packed {
    logic armLock;
    logic disarmLock;
    logic engageLock;
    logic dropLock;
  } lockStrobe_t;
endpackage

// File: rtl/bha_lock_path.sv
module bha_lock_path
  import bha_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  lockStrobe_t strobe,
  output logic        lockArmed,
  output logic        lockActive
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockArmed <= 1'b0;
    end else if (strobe.disarmLock) begin
      lockArmed <= 1'b0;
    end else if (strobe.armLock) begin
      lockArmed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockActive <= 1'b0;
    end else if (strobe.dropLock) begin
      lockActive <= 1'b0;
    end else if (strobe.engageLock) begin
      lockActive <= 1'b1;
    end
  end

  // R3: completion always releases the lock on the next edge
  p_lock_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dropLock |=> !lockActive);
endmodule

// File: rtl/bha_ctrl.sv
module bha_ctrl
  import bha_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BusStateW-1:0] busState,
  input  logic                 queueFull,
  input  logic                 biuStall,
  input  logic                 instrStart,
  input  logic                 lockPrefix,
  input  logic                 memAccess,
  input  logic                 instrDone,
  input  logic                 holdReq,
  input  logic                 lockArmed,
  input  logic                 lockActive,
  output lockStrobe_t          strobe,
  output logic                 hlda,
  output logic                 cpuBusEn
);
  arbState_e arbState, arbNext;
  logic armNow, atT1, atT4, releaseOk, grantNow;

  always_comb begin
    armNow            = instrStart & lockPrefix;
    strobe.dropLock   = instrDone;
    strobe.armLock    = armNow & ~instrDone;
    strobe.disarmLock = instrDone | (instrStart & ~lockPrefix);
    strobe.engageLock = memAccess & (lockArmed | armNow) & ~instrDone;
  end

  always_comb begin
    atT1      = (busState == BS_T1);
    atT4      = (busState == BS_T4);
    releaseOk = atT4 | (atT1 & (biuStall | queueFull));
    grantNow  = holdReq & releaseOk & ~lockActive & ~strobe.engageLock;
  end

  always_comb begin
    arbNext = arbState;
    unique case (arbState)
      ARB_OWN:     if (grantNow) arbNext = ARB_GRANTED;
      ARB_GRANTED: if (!holdReq) arbNext = ARB_RESUME;
      ARB_RESUME:  arbNext = ARB_OWN;
      default:     arbNext = ARB_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) arbState <= ARB_OWN;
    else       arbState <= arbNext;
  end

  assign hlda     = (arbState == ARB_GRANTED);
  assign cpuBusEn = (arbState == ARB_OWN);

  // R4: grant only at a T1 or T4 boundary
  p_grant_boundary_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hlda) |-> ($past(busState) == BS_T1 || $past(busState) == BS_T4));

  // R6: no grant while the lock is held
  p_grant_unlocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hlda) |-> !$past(lockActive));

  // R7: the two bus owners never coincide
  p_owner_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> !cpuBusEn);

  // R8: processor takes the bus back one edge after acknowledge falls
  p_resume_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hlda) |=> cpuBusEn);

  // R2: lock engages only after a memory access
  p_lock_on_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockActive) |-> $past(memAccess));
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bha_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BusStateW-1:0] busState,
  input  logic                 queueFull,
  input  logic                 biuStall,
  input  logic                 instrStart,
  input  logic                 lockPrefix,
  input  logic                 memAccess,
  input  logic                 instrDone,
  input  logic                 holdReq,
  output logic                 lockN,
  output logic                 hlda,
  output logic                 cpuBusEn
);
  lockStrobe_t strobe;
  logic lockArmed, lockActive;

  bha_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busState(busState), .queueFull(queueFull),
    .biuStall(biuStall), .instrStart(instrStart), .lockPrefix(lockPrefix),
    .memAccess(memAccess), .instrDone(instrDone), .holdReq(holdReq),
    .lockArmed(lockArmed), .lockActive(lockActive), .strobe(strobe),
    .hlda(hlda), .cpuBusEn(cpuBusEn)
  );

  bha_lock_path u_lock (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lockArmed(lockArmed), .lockActive(lockActive)
  );

  assign lockN = ~lockActive;
endmodule

// File: tb/bus_hold_arbiter_test.sv
module bus_hold_arbiter_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busState = 3'd0;
  logic queueFull = 0, biuStall = 0, instrStart = 0, lockPrefix = 0;
  logic memAccess = 0, instrDone = 0, holdReq = 0;
  logic lockN, hlda, cpuBusEn;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bus_hold_arbiter uut (
    .clk(clk), .rstN(rstN), .busState(busState), .queueFull(queueFull),
    .biuStall(biuStall), .instrStart(instrStart), .lockPrefix(lockPrefix),
    .memAccess(memAccess), .instrDone(instrDone), .holdReq(holdReq),
    .lockN(lockN), .hlda(hlda), .cpuBusEn(cpuBusEn)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic quiet();
    instrStart = 0; lockPrefix = 0; memAccess = 0; instrDone = 0;
  endtask

  task automatic letGo(input logic wasGranted);
    holdReq = 0; busState = 3'd0; queueFull = 0; biuStall = 0;
    cyc();
    check("R8 hlda after withdraw", hlda, 1'b0);
    check("R8 busEn gap", cpuBusEn, !wasGranted);
    cyc();
    check("R8 busEn resumed", cpuBusEn, 1'b1);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    check("R1 lockN", lockN, 1'b1);
    check("R1 hlda", hlda, 1'b0);
    check("R1 cpuBusEn", cpuBusEn, 1'b1);
    rstN = 1;
    cyc();

    // R4 R5 sweep unlocked
    for (int bs = 0; bs < 5; bs++)
      for (int qf = 0; qf < 2; qf++)
        for (int st = 0; st < 2; st++) begin
          logic exp;
          exp = (bs == 4) || (bs == 1 && (qf == 1 || st == 1));
          busState = 3'(bs); queueFull = qf[0]; biuStall = st[0]; holdReq = 1;
          cyc();
          check("R4/R5 grant", hlda, exp);
          check("R7 busEn low with grant", cpuBusEn, !exp);
          if (exp) begin
            busState = 3'd2;
            cyc(); cyc();
            check("R7 hlda held", hlda, 1'b1);
            check("R7 busEn held", cpuBusEn, 1'b0);
          end
          letGo(exp);
        end

    // R2 lock engage
    instrStart = 1; lockPrefix = 1;
    cyc(); quiet();
    check("R2 armed not engaged", lockN, 1'b1);
    memAccess = 1;
    cyc(); quiet();
    check("R2 engaged on access", lockN, 1'b0);

    // R6 sweep while locked
    for (int bs = 0; bs < 5; bs++)
      for (int qf = 0; qf < 2; qf++)
        for (int st = 0; st < 2; st++) begin
          busState = 3'(bs); queueFull = qf[0]; biuStall = st[0]; holdReq = 1;
          cyc();
          check("R6 no grant locked", hlda, 1'b0);
          check("R6 busEn kept", cpuBusEn, 1'b1);
        end

    // R3 release then grant
    busState = 3'd1; queueFull = 1; holdReq = 1; instrDone = 1;
    cyc(); quiet();
    check("R3 lock released", lockN, 1'b1);
    check("R6 no grant on release edge", hlda, 1'b0);
    cyc();
    check("R5 grant after release", hlda, 1'b1);
    letGo(1'b1);

    // R2 unprefixed never locks
    instrStart = 1; lockPrefix = 0; memAccess = 1;
    cyc(); instrStart = 0;
    cyc(); cyc(); quiet();
    check("R2 unprefixed no lock", lockN, 1'b1);

    // R3 done beats access in same cycle
    instrStart = 1; lockPrefix = 1;
    cyc(); quiet();
    memAccess = 1; instrDone = 1;
    cyc(); quiet();
    check("R3 done wins", lockN, 1'b1);
    memAccess = 1;
    cyc(); quiet();
    check("R3 disarmed by done", lockN, 1'b1);

    // R9 unprefixed start cancels armed lock
    instrStart = 1; lockPrefix = 1;
    cyc(); quiet();
    instrStart = 1; lockPrefix = 0;
    cyc(); quiet();
    memAccess = 1;
    cyc(); quiet();
    check("R9 cancelled arm", lockN, 1'b1);

    // R2 access in start cycle engages
    instrStart = 1; lockPrefix = 1; memAccess = 1;
    cyc(); quiet();
    check("R2 same-cycle access", lockN, 1'b0);
    instrDone = 1;
    cyc(); quiet();
    check("R3 drop", lockN, 1'b1);

    // R8 no regrant in resume gap
    busState = 3'd4; holdReq = 1;
    cyc();
    check("R5 T4 grant", hlda, 1'b1);
    holdReq = 0;
    cyc();
    holdReq = 1;
    check("R8 hlda low", hlda, 1'b0);
    cyc();
    check("R8 no regrant in gap", hlda, 1'b0);
    check("R8 busEn back", cpuBusEn, 1'b1);
    cyc();
    check("R5 regrant after gap", hlda, 1'b1);
    letGo(1'b1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule